// File: doc/BRIEF.md
# DRAM Access Sequencer with Self-Refresh Scheduling

This block sits between a simple synchronous request port and an asynchronous, page-organised DRAM module. The module has a 9-bit data path: 8 data bits plus a parity bit. A host asks for one byte at a time. It drives `req_i`, `we_i`, the word address and the write data, and holds them until `ack_o` pulses. The controller splits the word address into a row half and a column half and places them one after the other on the shared address pins. It strobes the row, then the column, and drives the write enable.

Inside the block a free-running timer divides the refresh window by the number of rows. Each time it expires, a refresh request is raised. The refresh is issued in the mode where the column strobe falls first and the DRAM supplies the row from its own counter. A pending refresh wins against a new host request, but it never cuts short an access already under way. The host therefore sees a variable latency.

Parity on writes is the XOR of the data byte and is driven on a separate parity pin. On reads, the returned parity bit is compared against the XOR of the returned byte.

Top module: `dram_ctrl`

## Requirements
- R1: A host access is split into a row half `addr_i[2*AW-1:AW]` and a column half `addr_i[AW-1:0]`. The row half is driven while `dram_ras_no` falls. `dram_cas_no` falls exactly T_RCD cycles later, with the column half on `dram_addr_o`. The column strobe never falls first for a data access.
- R2: A refresh pulls `dram_cas_no` low while `dram_ras_no` is high, with `dram_addr_o` all zero and `dram_we_no` high. `dram_ras_no` follows exactly T_CSR cycles later.
- R3: With no host traffic, refresh cycles start exactly REFRESH_WINDOW_CYC / 2**AW clock cycles apart.
- R4: Between any two low periods of `dram_ras_no`, the strobe stays high for at least T_RP cycles.
- R5: A refresh that is pending when the controller is idle is served before a host request that is present in the same cycle. The request's row strobe then falls exactly T_CSR+T_RAS+T_RP+1 cycles after the refresh column strobe fell.
- R6: For a write, `dram_we_no` is already low when `dram_ras_no` falls and stays low through the column strobe. `dram_d_o` carries the byte, and `dram_dp_o` equals the XOR of its 8 bits (even parity).
- R7: For a read, the byte on `dram_q_i` is captured at the end of the T_CAS-cycle column strobe. It appears on `rdata_o` with a one-cycle `rvalid_o` that coincides with `ack_o`.
- R8: `perr_o` pulses together with `rvalid_o` exactly when `dram_qp_i` differs from the XOR of `dram_q_i`.
- R9: Each request produces one `ack_o` pulse of exactly one cycle. `rvalid_o` stays low on write acknowledgements.
- R10: While `rst_ni` is low, all three strobes are high and `ack_o` and `rvalid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request, held until ack |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2*AW | Word address, row half on top |
| wdata_i | input | DW | Write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Read byte |
| rvalid_o | output | 1 | Read data valid pulse |
| perr_o | output | 1 | Read parity mismatch pulse |
| dram_addr_o | output | AW | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_d_o | output | DW | Data to the DRAM |
| dram_dp_o | output | 1 | Parity bit to the DRAM |
| dram_q_i | input | DW | Data from the DRAM |
| dram_qp_i | input | 1 | Parity bit from the DRAM |

## Verification
Some orderings hold on every cycle and are watched by assertions:
- the row strobe before the column strobe on accesses, and the reverse order with a zero address on refreshes;
- the minimum row-strobe high time;
- write enable settled before the column strobe falls;
- the shapes of the acknowledge, valid and parity-error pulses.

Other behaviour needs the bench's scenarios and its DRAM model:
- the exact refresh spacing;
- the refresh-first decision when both contend in the same cycle, and the resulting latency;
- that each byte and parity bit read back matches what was written;
- that a corrupted parity bit is flagged.

// File: rtl/dramc_pkg.sv
`timescale 1ns/1ps
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_RFC,
    ST_RFR,
    ST_PRE
  } seq_st_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dramc_refresh_timer.sv
`timescale 1ns/1ps
module dramc_refresh_timer #(
  parameter int unsigned INTERVAL = 1953
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic pend_o
);
  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q;
  logic          tick;
  logic          pend_q;

  assign tick   = (cnt_q == CW'(INTERVAL - 1));
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a new tick outranks the take in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (tick) begin
      pend_q <= 1'b1;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  AST_TAKE_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q) else $error("take without pending refresh"); // R5
endmodule

// File: rtl/dramc_parity.sv
`timescale 1ns/1ps
module dramc_parity #(
  parameter int unsigned DW  = 8,
  parameter bit          ODD = 1'b0
) (
  input  logic [DW-1:0] wdata_i,
  output logic          wpar_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          rpar_i,
  output logic          err_o
);
  generate
    if (ODD) begin : g_odd
      assign wpar_o = ~^wdata_i;
      assign err_o  = rpar_i ^ (~^rdata_i);
    end else begin : g_even
      assign wpar_o = ^wdata_i;
      assign err_o  = rpar_i ^ (^rdata_i);
    end
  endgenerate
endmodule

// File: rtl/dramc_seq.sv
`timescale 1ns/1ps
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int unsigned AW    = 9,
  parameter int unsigned DW    = 8,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_RAS = 5,
  parameter int unsigned T_RP  = 4,
  parameter int unsigned T_CSR = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [2*AW-1:0] addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            ref_pend_i,
  output logic            ref_take_o,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o,
  output logic            perr_o,
  input  logic [DW-1:0]   rd_data_i,
  input  logic            rd_perr_i,
  output logic [AW-1:0]   addr_o,
  output logic            ras_n_o,
  output logic            cas_n_o,
  output logic            we_n_o,
  output logic [DW-1:0]   wr_data_o
);
  localparam int unsigned TMAX = umax(umax(umax(T_RCD, T_CAS), umax(T_RAS, T_RP)), T_CSR);
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned HW   = $clog2(T_RP + 2);

  seq_st_e         state_q;
  logic [TW-1:0]   cnt_q;
  logic            cnt_done;
  logic [AW-1:0]   row_q, col_q;
  logic            wr_q;
  logic [DW-1:0]   wdat_q;
  logic [DW-1:0]   rdata_q;
  logic            ack_q, rvalid_q, perr_q;

  assign cnt_done   = (cnt_q == '0);
  assign ref_take_o = (state_q == ST_IDLE) && ref_pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      row_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      wdat_q   <= '0;
      rdata_q  <= '0;
      ack_q    <= 1'b0;
      rvalid_q <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      ack_q    <= 1'b0;
      rvalid_q <= 1'b0;
      perr_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          // refresh wins over a request seen in the same cycle
          if (ref_pend_i) begin
            state_q <= ST_RFC;
            cnt_q   <= TW'(T_CSR - 1);
          end else if (req_i) begin
            state_q <= ST_ROW;
            cnt_q   <= TW'(T_RCD - 1);
            row_q   <= addr_i[2*AW-1:AW];
            col_q   <= addr_i[AW-1:0];
            wr_q    <= we_i;
            wdat_q  <= wdata_i;
          end
        end
        ST_ROW: begin
          if (cnt_done) begin
            state_q <= ST_COL;
            cnt_q   <= TW'(T_CAS - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_COL: begin
          if (cnt_done) begin
            state_q <= ST_PRE;
            cnt_q   <= TW'(T_RP - 1);
            ack_q   <= 1'b1;
            if (!wr_q) begin
              rdata_q  <= rd_data_i;
              rvalid_q <= 1'b1;
              perr_q   <= rd_perr_i;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RFC: begin
          if (cnt_done) begin
            state_q <= ST_RFR;
            cnt_q   <= TW'(T_RAS - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RFR: begin
          if (cnt_done) begin
            state_q <= ST_PRE;
            cnt_q   <= TW'(T_RP - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt_done) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ras_n_o   = !(state_q inside {ST_ROW, ST_COL, ST_RFR});
  assign cas_n_o   = !(state_q inside {ST_COL, ST_RFC, ST_RFR});
  assign we_n_o    = !(wr_q && (state_q inside {ST_ROW, ST_COL}));
  assign addr_o    = (state_q == ST_ROW) ? row_q :
                     (state_q == ST_COL) ? col_q : '0;
  assign wr_data_o = wdat_q;
  assign ack_o     = ack_q;
  assign rvalid_o  = rvalid_q;
  assign perr_o    = perr_q;
  assign rdata_o   = rdata_q;

  // row-strobe high time, saturating, used only by the precharge check
  logic [HW-1:0] ras_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_hi_q <= HW'(T_RP);
    end else if (!ras_n_o) begin
      ras_hi_q <= '0;
    end else if (ras_hi_q < HW'(T_RP)) begin
      ras_hi_q <= ras_hi_q + 1'b1;
    end
  end

  AST_ROW_BEFORE_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !ras_n_o) |-> $past(!ras_n_o)) else $error("column before row"); // R1
  AST_CBR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> ($past(!cas_n_o) && we_n_o)) else $error("bad refresh order"); // R2
  AST_CBR_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && ras_n_o) |-> (addr_o == '0)) else $error("address during refresh"); // R2
  AST_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (ras_hi_q >= HW'(T_RP))) else $error("precharge too short"); // R4
  AST_WE_BEFORE_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !we_n_o) |-> $past(!we_n_o)) else $error("late write enable"); // R6
  AST_RVALID_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ack_o) else $error("rvalid without ack"); // R7
  AST_PERR_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> rvalid_o) else $error("perr without rvalid"); // R8
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o) else $error("ack wider than one cycle"); // R9
endmodule

// File: rtl/dram_ctrl.sv
`timescale 1ns/1ps
module dram_ctrl #(
  parameter int unsigned AW                 = 9,
  parameter int unsigned DW                 = 8,
  parameter int unsigned T_RCD              = 2,
  parameter int unsigned T_CAS              = 2,
  parameter int unsigned T_RAS              = 5,
  parameter int unsigned T_RP               = 4,
  parameter int unsigned T_CSR              = 1,
  parameter int unsigned REFRESH_WINDOW_CYC = 1000000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [2*AW-1:0] addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o,
  output logic            perr_o,
  output logic [AW-1:0]   dram_addr_o,
  output logic            dram_ras_no,
  output logic            dram_cas_no,
  output logic            dram_we_no,
  output logic [DW-1:0]   dram_d_o,
  output logic            dram_dp_o,
  input  logic [DW-1:0]   dram_q_i,
  input  logic            dram_qp_i
);
  localparam int unsigned ROWS     = 2 ** AW;
  localparam int unsigned INTERVAL = REFRESH_WINDOW_CYC / ROWS;

  logic          ref_pend, ref_take, rd_perr;
  logic [DW-1:0] wr_data;

  dramc_refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (ref_take),
    .pend_o (ref_pend)
  );

  dramc_parity #(.DW(DW), .ODD(1'b0)) u_par (
    .wdata_i (wr_data),
    .wpar_o  (dram_dp_o),
    .rdata_i (dram_q_i),
    .rpar_i  (dram_qp_i),
    .err_o   (rd_perr)
  );

  dramc_seq #(
    .AW(AW), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ref_pend_i (ref_pend),
    .ref_take_o (ref_take),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .perr_o     (perr_o),
    .rd_data_i  (dram_q_i),
    .rd_perr_i  (rd_perr),
    .addr_o     (dram_addr_o),
    .ras_n_o    (dram_ras_no),
    .cas_n_o    (dram_cas_no),
    .we_n_o     (dram_we_no),
    .wr_data_o  (wr_data)
  );

  assign dram_d_o = wr_data;
endmodule

// File: tb/dram_ctrl_tb.sv
`timescale 1ns/1ps
module dram_ctrl_tb;
  localparam int AW       = 9;
  localparam int T_RCD    = 2;
  localparam int T_CAS    = 2;
  localparam int T_RAS    = 4;
  localparam int T_RP     = 3;
  localparam int T_CSR    = 2;
  localparam int INTERVAL = 60;
  localparam int WINDOW   = INTERVAL * (2 ** AW);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [2*AW-1:0] addr = '0;
  logic [7:0]      wdata = '0;
  logic            ack, rvalid, perr;
  logic [7:0]      rdata;
  logic [AW-1:0]   d_addr;
  logic            ras_n, cas_n, we_n, dp;
  logic [7:0]      d_out;
  logic [7:0]      q_m = '0;
  logic            qp_m = 1'b0;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dram_ctrl #(
    .AW(AW), .DW(8), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS),
    .T_RP(T_RP), .T_CSR(T_CSR), .REFRESH_WINDOW_CYC(WINDOW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .rvalid_o(rvalid),
    .perr_o(perr), .dram_addr_o(d_addr), .dram_ras_no(ras_n),
    .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_d_o(d_out),
    .dram_dp_o(dp), .dram_q_i(q_m), .dram_qp_i(qp_m)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // DRAM model and port monitor
  logic [8:0] mem [int];
  logic [7:0] shadow [int];
  int  cyc = 0, ras_hi = 100, ref_cnt = 0, acc_cnt = 0;
  int  ref_cas_cyc = 0, acc_ras_cyc = 0, exp_addr = 0;
  bit  prev_ras = 1'b1, prev_cas = 1'b1, we_at_ras = 1'b1, flip = 1'b0, idle_mon = 1'b0;
  logic [AW-1:0] row_m = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_ras && !ras_n) begin
        chk("R4 precharge", (ras_hi >= T_RP) ? T_RP : ras_hi, T_RP);
        if (!cas_n) begin
          chk("R2 cas-to-ras", cyc - ref_cas_cyc, T_CSR);
        end else begin
          row_m       = d_addr;
          we_at_ras   = we_n;
          acc_ras_cyc = cyc;
          acc_cnt++;
        end
      end
      if (prev_cas && !cas_n) begin
        if (ras_n) begin
          chk("R2 refresh addr", int'(d_addr), 0);
          chk("R2 refresh we", int'(we_n), 1);
          if (idle_mon) chk("R3 refresh gap", cyc - ref_cas_cyc, INTERVAL);
          ref_cas_cyc = cyc;
          ref_cnt++;
        end else begin
          int key;
          key = int'({row_m, d_addr});
          chk("R1 ras-to-cas", cyc - acc_ras_cyc, T_RCD);
          chk("R1 address", key, exp_addr);
          if (!we_n) begin
            chk("R6 we early", int'(we_at_ras), 0);
            chk("R6 parity", int'(dp), int'(^d_out));
            mem[key] = {dp, d_out};
          end else begin
            if (mem.exists(key)) {qp_m, q_m} = mem[key];
            else {qp_m, q_m} = 9'd0;
            qp_m = qp_m ^ flip;
          end
        end
      end
      ras_hi   = ras_n ? ras_hi + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic do_op(input bit w, input int a, input logic [7:0] d, input bit fl);
    exp_addr = a;
    flip     = fl;
    req      = 1'b1;
    we       = w;
    addr     = (2*AW)'(a);
    wdata    = d;
    forever begin
      @(negedge clk); #1;
      if (ack) break;
    end
    if (w) begin
      chk("R9 no rvalid on write", int'(rvalid), 0);
      shadow[a] = d;
    end else begin
      chk("R7 rvalid", int'(rvalid), 1);
      chk("R7 read data", int'(rdata), int'(shadow[a]));
      chk("R8 parity flag", int'(perr), int'(fl));
    end
    req = 1'b0;
    @(negedge clk); #1;
    chk("R9 ack pulse", int'(ack), 0);
  endtask

  task automatic wait_ref();
    int r;
    r = ref_cnt;
    forever begin
      @(negedge clk); #1;
      if (ref_cnt != r) break;
    end
  endtask

  task automatic prio_test(input bit w, input int a, input logic [7:0] d);
    int r0;
    repeat (3) @(negedge clk);
    wait_ref();
    repeat (INTERVAL - 1) @(negedge clk);
    #1;
    r0 = ref_cnt;
    do_op(w, a, d, 1'b0);
    chk("R5 refresh first", ref_cnt - r0, 1);
    chk("R5 held-off latency", acc_ras_cyc - ref_cas_cyc, T_CSR + T_RAS + T_RP + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R10 ras", int'(ras_n), 1);
    chk("R10 cas", int'(cas_n), 1);
    chk("R10 we", int'(we_n), 1);
    chk("R10 ack", int'(ack), 0);
    chk("R10 rvalid", int'(rvalid), 0);
    rst_n = 1'b1;

    // directed corners: extreme row and column values
    do_op(1'b1, 0, 8'h00, 1'b0);
    do_op(1'b1, (1 << (2*AW)) - 1, 8'hFF, 1'b0);
    do_op(1'b1, ((1 << AW) - 1) << AW, 8'hA5, 1'b0);
    do_op(1'b1, (1 << AW) - 1, 8'h5A, 1'b0);
    do_op(1'b0, (1 << (2*AW)) - 1, 8'h00, 1'b0);
    do_op(1'b0, 0, 8'h00, 1'b1);
    do_op(1'b0, ((1 << AW) - 1) << AW, 8'h00, 1'b0);
    do_op(1'b0, (1 << AW) - 1, 8'h00, 1'b1);

    // R3: idle refresh spacing after two settling refreshes
    wait_ref();
    wait_ref();
    idle_mon = 1'b1;
    repeat (3) wait_ref();
    idle_mon = 1'b0;

    // R5: request and refresh contend in the same idle cycle
    prio_test(1'b1, 5, 8'h3C);
    prio_test(1'b0, 5, 8'h00);

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      int  row, col, a;
      bit  w, fl;
      row = (($urandom % 4) == 0) ? (1 << AW) - 1 : int'($urandom % 4);
      col = (($urandom % 4) == 0) ? (1 << AW) - 1 : int'($urandom % 4);
      a   = (row << AW) | col;
      w   = !shadow.exists(a) || (($urandom % 2) == 0);
      fl  = !w && (($urandom % 6) == 0);
      do_op(w, a, 8'($urandom), fl);
      if (($urandom % 5) == 0) repeat (int'($urandom % 8)) @(negedge clk);
    end

    chk("R3 refreshes seen", (ref_cnt > 0) ? 1 : 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule